// File: doc/BRIEF.md
# Lowest-First Bitmap ID Allocator

This block hands out small integer identifiers from a fixed pool and takes them back. Every identifier owns one bit of an internal bitmap organised as words; a set bit means the identifier is in use, a clear bit means it can be handed out. After reset the whole pool is free.

An allocation walks the bitmap from word 0 upward. Any word in which every bit is set is passed over at one word per clock. In the first word that holds a clear bit, a single-cycle priority encoder finds the first clear bit counting down from the word's most significant bit. That bit is set, and the identifier word_index * WORD_W + offset is returned. When no word has a clear bit, the request completes with a failure. A free request clears the bit of the identifier it names in one step. Freeing an identifier that is already free changes nothing and is reported as an error.

Each requester raises its request and holds it until the matching grant pulse, then drops it on the following cycle. The default pool is 1024 words of 32 bits, which gives 32,768 identifiers.

Top module: `id_bitmap_alloc`

## Requirements
- R1: After reset, every identifier is free, `busy` and `full` are low and neither grant is asserted.
- R2: A successful allocation returns the lowest free identifier. The identifier is word_index * WORD_W + offset, where offset 0 is the most significant bit of the word and offset WORD_W-1 is the least significant bit.
- R3: An allocated identifier is never returned again until it has been freed.
- R4: An allocation whose result lies in word k raises `alloc_gnt` k+2 rising edges after the edge that accepted the request, counting the accepting edge as the first. A failed allocation takes NUM_WORDS+1 edges.
- R5: When every identifier is allocated, an allocation completes with `alloc_ok` low during `alloc_gnt`, and `full` is high.
- R6: Freeing an allocated identifier makes it free again. `free_gnt` is high after one edge, `free_err` is low, and the identifier is again available to later allocations.
- R7: Freeing an identifier that is already free raises `free_err` together with `free_gnt`. The bitmap, `full` and the result of later allocations stay as they would have been without that request.
- R8: `full` is high exactly while every identifier is allocated. It changes only on the edge that raises a grant, and it drops after any successful free.
- R9: When an allocation request and a free request are both present while the block is idle, the allocation is served first. The free is served after the allocation grant.
- R10: `busy` rises on the edge after a request is accepted and stays high through the grant cycle. Requests that arrive while `busy` is high are not accepted. Each grant is a single-cycle pulse, the two grants never occur in the same cycle, and `busy` is low on the cycle after a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Allocation request, held until `alloc_gnt` |
| alloc_gnt | output | 1 | One-cycle completion pulse for an allocation |
| alloc_ok | output | 1 | High with `alloc_gnt` when an identifier was obtained |
| alloc_id | output | ID_W | Allocated identifier, valid while `alloc_ok` is high |
| free_req | input | 1 | Free request, held until `free_gnt` |
| free_id | input | ID_W | Identifier to release |
| free_gnt | output | 1 | One-cycle completion pulse for a free |
| free_err | output | 1 | High with `free_gnt` when the identifier was already free |
| busy | output | 1 | High while a request is being served |
| full | output | 1 | High while every identifier is allocated |

## Verification
The hardest state to reach from the ports is a completely full pool followed by a failing allocation. Reaching it requires every identifier to be allocated in turn, with each scan longer than the one before. The bench therefore builds the block with eight words, so that filling the pool is affordable. It then drives allocations until its reference model reports no free identifier, checks the failure and its NUM_WORDS+1 latency, and frees one identifier in the middle of the pool to confirm that `full` drops and that this identifier is the next one returned. A mixed random phase with a fixed seed brings the pool to partly filled, scattered layouts. These layouts exercise word skipping at varying depths, and the random frees also target identifiers that are already free.

// File: rtl/id_bitmap_alloc_pkg.sv
package id_bitmap_alloc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_DONE = 2'd2
   } alloc_state_e;

   typedef enum logic {
      OP_ALLOC = 1'b0,
      OP_FREE  = 1'b1
   } alloc_op_e;

endpackage

// File: rtl/id_bitmap_first_zero.sv
// Locates the first clear bit of a word, scanning from the MSB down.
// off = 0 means bit WORD_W-1.
module id_bitmap_first_zero #(
   parameter int WORD_W   = 32,
   parameter bit FAST_ENC = 1'b1,
   localparam int OFF_W   = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] word,
   output logic              found,
   output logic [OFF_W-1:0]  off
);

   generate
      if (FAST_ENC) begin : g_isolate
         // reverse and invert so the wanted bit becomes the lowest set bit
         logic [WORD_W-1:0] rev;
         logic [WORD_W-1:0] iso;
         always_comb begin
            for (int i = 0; i < WORD_W; i++) begin
               rev[i] = ~word[WORD_W-1-i];
            end
            iso = rev & (~rev + 1'b1);
         end
         always_comb begin
            off = '0;
            for (int i = 0; i < WORD_W; i++) begin
               if (iso[i]) begin
                  off = off | OFF_W'(i);
               end
            end
         end
         assign found = |rev;
      end else begin : g_linear
         always_comb begin
            found = 1'b0;
            off   = '0;
            for (int i = WORD_W - 1; i >= 0; i--) begin
               if (!word[i] && !found) begin
                  found = 1'b1;
                  off   = OFF_W'(WORD_W - 1 - i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/id_bitmap_store.sv
// Register array holding the allocation bitmap, one read and one write port.
module id_bitmap_store #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 1024,
   localparam int WIDX_W   = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDX_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data
);

   logic [WORD_W-1:0] mem [NUM_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            mem[w] <= '0;
         end
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/id_bitmap_occupancy.sv
// Counts allocated identifiers and reports a fully used pool.
module id_bitmap_occupancy #(
   parameter int TOTAL = 32768,
   localparam int CNT_W = $clog2(TOTAL + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic full
);

   logic [CNT_W-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
      end else if (inc && !dec) begin
         used_q <= used_q + 1'b1;
      end else if (dec && !inc) begin
         used_q <= used_q - 1'b1;
      end
   end

   assign full = (used_q == CNT_W'(TOTAL));

endmodule

// File: rtl/id_bitmap_alloc.sv
module id_bitmap_alloc
   import id_bitmap_alloc_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 1024,
   parameter bit FAST_ENC  = 1'b1,
   localparam int OFF_W    = $clog2(WORD_W),
   localparam int WIDX_W   = $clog2(NUM_WORDS),
   localparam int ID_W     = OFF_W + WIDX_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_req,
   output logic            alloc_gnt,
   output logic            alloc_ok,
   output logic [ID_W-1:0] alloc_id,
   input  logic            free_req,
   input  logic [ID_W-1:0] free_id,
   output logic            free_gnt,
   output logic            free_err,
   output logic            busy,
   output logic            full
);

   localparam int TOTAL = WORD_W * NUM_WORDS;

   // elaboration-time parameter checks
   generate
      if (WORD_W < 2 || (1 << OFF_W) != WORD_W) begin : g_bad_word
         $error("WORD_W must be a power of two of at least 2");
      end
      if (NUM_WORDS < 2 || (1 << WIDX_W) != NUM_WORDS) begin : g_bad_depth
         $error("NUM_WORDS must be a power of two of at least 2");
      end
   endgenerate

   alloc_state_e      state_q;
   alloc_op_e         op_q;
   logic [WIDX_W-1:0] widx_q;
   logic [ID_W-1:0]   res_id_q;
   logic              res_flag_q;

   logic [WIDX_W-1:0] rd_addr;
   logic [WORD_W-1:0] rd_data;
   logic              wr_en;
   logic [WORD_W-1:0] wr_data;
   logic              cnt_inc;
   logic              cnt_dec;

   logic              zf_found;
   logic [OFF_W-1:0]  zf_off;

   logic [WIDX_W-1:0] free_word;
   logic [OFF_W-1:0]  free_bit;
   logic [WORD_W-1:0] free_mask;
   logic [WORD_W-1:0] alloc_mask;

   // offset counts from the MSB, so the bit position is its complement
   assign free_word = free_id[ID_W-1:OFF_W];
   assign free_bit  = ~free_id[OFF_W-1:0];

   always_comb begin
      free_mask  = '0;
      free_mask[free_bit] = 1'b1;
      alloc_mask = '0;
      alloc_mask[~zf_off] = 1'b1;
   end

   assign rd_addr = (state_q == ST_IDLE) ? free_word : widx_q;

   id_bitmap_store #(
      .WORD_W   (WORD_W),
      .NUM_WORDS(NUM_WORDS)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .wr_en  (wr_en),
      .wr_addr(rd_addr),
      .wr_data(wr_data)
   );

   id_bitmap_first_zero #(
      .WORD_W  (WORD_W),
      .FAST_ENC(FAST_ENC)
   ) u_first_zero (
      .word (rd_data),
      .found(zf_found),
      .off  (zf_off)
   );

   id_bitmap_occupancy #(
      .TOTAL(TOTAL)
   ) u_occupancy (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cnt_inc),
      .dec  (cnt_dec),
      .full (full)
   );

   // bitmap update: set during a successful scan step, clear on a valid free
   always_comb begin
      wr_en   = 1'b0;
      wr_data = rd_data;
      cnt_inc = 1'b0;
      cnt_dec = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (!alloc_req && free_req && rd_data[free_bit]) begin
               wr_en   = 1'b1;
               wr_data = rd_data & ~free_mask;
               cnt_dec = 1'b1;
            end
         end
         ST_SCAN: begin
            if (zf_found) begin
               wr_en   = 1'b1;
               wr_data = rd_data | alloc_mask;
               cnt_inc = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_q       <= OP_ALLOC;
         widx_q     <= '0;
         res_id_q   <= '0;
         res_flag_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (alloc_req) begin
                  state_q <= ST_SCAN;
                  op_q    <= OP_ALLOC;
                  widx_q  <= '0;
               end else if (free_req) begin
                  state_q    <= ST_DONE;
                  op_q       <= OP_FREE;
                  res_flag_q <= !rd_data[free_bit];
               end
            end
            ST_SCAN: begin
               if (zf_found) begin
                  state_q    <= ST_DONE;
                  res_id_q   <= {widx_q, zf_off};
                  res_flag_q <= 1'b1;
               end else if (widx_q == WIDX_W'(NUM_WORDS - 1)) begin
                  state_q    <= ST_DONE;
                  res_flag_q <= 1'b0;
               end else begin
                  widx_q <= widx_q + 1'b1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign alloc_gnt = (state_q == ST_DONE) && (op_q == OP_ALLOC);
   assign free_gnt  = (state_q == ST_DONE) && (op_q == OP_FREE);
   assign alloc_ok  = alloc_gnt && res_flag_q;
   assign free_err  = free_gnt && res_flag_q;
   assign alloc_id  = res_id_q;

endmodule

// File: rtl/id_bitmap_alloc_chk.sv
module id_bitmap_alloc_chk #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 1024,
   localparam int ID_W     = $clog2(WORD_W) + $clog2(NUM_WORDS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            alloc_req,
   input logic            alloc_gnt,
   input logic            alloc_ok,
   input logic [ID_W-1:0] alloc_id,
   input logic            free_req,
   input logic [ID_W-1:0] free_id,
   input logic            free_gnt,
   input logic            free_err,
   input logic            busy,
   input logic            full
);

   // R10
   alloc_gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |=> !alloc_gnt);

   // R10
   free_gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_gnt |=> !free_gnt);

   // R10
   gnt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_gnt && free_gnt));

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((alloc_req || free_req) && !busy) |=> busy);

   // R10
   gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_gnt || free_gnt) |=> !busy);

   // R5
   fail_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_gnt && !alloc_ok) |-> full);

   // R8
   full_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(full) |-> (alloc_gnt || free_gnt));

   // R6
   free_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_gnt && !free_err) |-> !full);

   // R7
   free_err_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_err |-> $stable(full));

endmodule

bind id_bitmap_alloc id_bitmap_alloc_chk #(
   .WORD_W   (WORD_W),
   .NUM_WORDS(NUM_WORDS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .alloc_req(alloc_req),
   .alloc_gnt(alloc_gnt),
   .alloc_ok (alloc_ok),
   .alloc_id (alloc_id),
   .free_req (free_req),
   .free_id  (free_id),
   .free_gnt (free_gnt),
   .free_err (free_err),
   .busy     (busy),
   .full     (full)
);

// File: tb/id_bitmap_alloc_bench.sv
module id_bitmap_alloc_bench;

   localparam int WW    = 32;
   localparam int NW    = 8;
   localparam int TOTAL = WW * NW;
   localparam int IDW   = $clog2(TOTAL);

   logic           clk = 1'b0;
   logic           rst_n;
   logic           alloc_req;
   logic           alloc_gnt;
   logic           alloc_ok;
   logic [IDW-1:0] alloc_id;
   logic           free_req;
   logic [IDW-1:0] free_id;
   logic           free_gnt;
   logic           free_err;
   logic           busy;
   logic           full;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   bit model [TOTAL];

   always #10 clk = ~clk;

   id_bitmap_alloc #(
      .WORD_W   (WW),
      .NUM_WORDS(NW)
   ) u_id_bitmap_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_req(alloc_req),
      .alloc_gnt(alloc_gnt),
      .alloc_ok (alloc_ok),
      .alloc_id (alloc_id),
      .free_req (free_req),
      .free_id  (free_id),
      .free_gnt (free_gnt),
      .free_err (free_err),
      .busy     (busy),
      .full     (full)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int i = 0; i < TOTAL; i++) begin
         if (!model[i]) return i;
      end
      return -1;
   endfunction

   function automatic bit model_full();
      return lowest_free() < 0;
   endfunction

   task automatic do_alloc();
      int exp = lowest_free();
      int cyc = 0;
      @(negedge clk);
      alloc_req = 1'b1;
      do begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end while (!alloc_gnt && cyc < 5000);
      alloc_req = 1'b0;
      if (exp < 0) begin
         chk(alloc_ok == 1'b0, "R5 alloc_ok on full pool", alloc_ok, 0);
         chk(full == 1'b1, "R5 full on failed alloc", full, 1);
         chk(cyc == NW + 1, "R4 failure latency", cyc, NW + 1);
      end else begin
         chk(alloc_ok == 1'b1, "R2 alloc_ok", alloc_ok, 1);
         chk(int'(alloc_id) == exp, "R2/R3 lowest free id", alloc_id, exp);
         chk(cyc == exp / WW + 2, "R4 alloc latency", cyc, exp / WW + 2);
         model[exp] = 1'b1;
         chk(full == model_full(), "R8 full after alloc", full, model_full());
      end
   endtask

   task automatic do_free(input int id);
      bit exp_err = !model[id];
      int cyc = 0;
      @(negedge clk);
      free_id  = IDW'(id);
      free_req = 1'b1;
      do begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end while (!free_gnt && cyc < 5000);
      free_req = 1'b0;
      if (exp_err) begin
         chk(free_err == 1'b1, "R7 free of free id", free_err, 1);
      end else begin
         chk(free_err == 1'b0, "R6 free_err on valid free", free_err, 0);
      end
      chk(cyc == 1, "R6 free latency", cyc, 1);
      model[id] = 1'b0;
      chk(full == model_full(), "R8 full after free", full, model_full());
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int cyc;
      int exp;
      void'($urandom(32'd2024));
      for (int i = 0; i < TOTAL; i++) model[i] = 1'b0;
      rst_n     = 1'b0;
      alloc_req = 1'b0;
      free_req  = 1'b0;
      free_id   = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);
      chk(full == 1'b0, "R1 full after reset", full, 0);
      chk(alloc_gnt == 1'b0 && free_gnt == 1'b0, "R1 no grant after reset",
          alloc_gnt | free_gnt, 0);
      rst_n = 1'b1;

      // R1 / R2: first allocation gives 0, then a run across a word edge
      for (int i = 0; i < 40; i++) do_alloc();

      // R6 / R3: freed ids are handed out again lowest first
      do_free(5);
      do_alloc();
      do_free(35);
      do_free(3);
      do_alloc();
      do_alloc();

      // R7: freeing a free id changes nothing
      do_free(100);
      do_free(100);
      do_alloc();

      // R9 / R10: simultaneous requests, alloc first, busy during scan
      @(negedge clk);
      exp = lowest_free();
      alloc_req = 1'b1;
      free_req  = 1'b1;
      free_id   = IDW'(7);
      @(posedge clk);
      @(negedge clk);
      chk(busy == 1'b1, "R10 busy during scan", busy, 1);
      cyc = 0;
      while (!alloc_gnt && cyc < 5000) begin
         chk(free_gnt == 1'b0, "R9 free held back", free_gnt, 0);
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      alloc_req = 1'b0;
      chk(free_gnt == 1'b0, "R9 no free grant with alloc grant", free_gnt, 0);
      chk(int'(alloc_id) == exp, "R9 alloc served first", alloc_id, exp);
      model[exp] = 1'b1;
      cyc = 0;
      do begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end while (!free_gnt && cyc < 5000);
      free_req = 1'b0;
      chk(cyc == 2, "R9 free served after alloc", cyc, 2);
      chk(free_err == 1'b0, "R9 queued free valid", free_err, 0);
      model[7] = 1'b0;
      do_alloc();

      // mixed random traffic
      for (int n = 0; n < 400; n++) begin
         if (($urandom % 3) != 0) begin
            do_alloc();
         end else begin
            do_free(int'($urandom % TOTAL));
         end
      end

      // R5 / R8: fill the pool, fail, then release one id
      while (!model_full()) do_alloc();
      @(negedge clk);
      chk(full == 1'b1, "R8 full when pool used up", full, 1);
      do_alloc();
      do_alloc();
      do_free(200);
      chk(full == 1'b0, "R8 full drops after free", full, 0);
      do_alloc();
      do_free(TOTAL - 1);
      do_free(TOTAL - 1);
      do_alloc();

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule